// File: doc/BRIEF.md
# Machine-Cycle Interval Timer

This block is a free-running interval timer that advances once per machine cycle. A machine cycle is a fixed number of input clocks, twelve by default. Software starts the timer by writing a configuration register with its run bit set. Writing that register with the run bit cleared halts the timer and zeroes both the count and the machine-cycle divider, so the next start always measures a full period.

When the count passes its all-ones value it wraps to zero and sets a sticky overflow flag. The count keeps running while the run bit stays set. The flag stays high until software writes the configuration register with the clear bit set. If a clear and an overflow land on the same clock edge, the overflow wins.

A separate interrupt-enable register holds a source enable and a global enable. The interrupt request is the flag gated by both enables. The CPU, the stack and the vector fetch sit outside this block.

Top module: `mc_interval_timer`

## Requirements
- R1: After a synchronous active-low reset, `ovf_flag` and `irq` are low, the timer is stopped and both enables are clear.
- R2: A `cfg_wr` with `cfg_wdata[4]`=1 starts the timer. The count advances once every PRESCALE clocks. `ovf_flag` first rises exactly PRESCALE*2^CNT_W clock edges after the write edge and is low before that.
- R3: A `cfg_wr` with `cfg_wdata[4]`=0 stops the timer and zeroes the count and the divider. A later start takes a full PRESCALE*2^CNT_W edges to the next overflow, whatever partial count existed before.
- R4: While the timer is stopped, `ovf_flag` never becomes set.
- R5: After an overflow the count wraps to zero and keeps running. The next overflow comes PRESCALE*2^CNT_W edges after the previous one.
- R6: `ovf_flag` stays set, also while stopped, until a `cfg_wr` with `cfg_wdata[5]`=1, which clears it at that edge.
- R7: When a clear write (`cfg_wdata[5]`=1) and an overflow fall on the same edge, `ovf_flag` stays set.
- R8: `irq` is high exactly when `ovf_flag`, the source enable (`ien_wdata[4]`, last written) and the global enable (`ien_wdata[7]`, last written) are all set.
- R9: `cfg_wdata` and `ien_wdata` have no effect unless their own strobe `cfg_wr` or `ien_wr` is high in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the configuration register |
| cfg_wdata | input | 8 | Configuration data: bit 4 run, bit 5 clear flag (write 1) |
| ien_wr | input | 1 | Write strobe for the interrupt-enable register |
| ien_wdata | input | 8 | Enable data: bit 4 source enable, bit 7 global enable |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Gated interrupt request |

## Verification
The bench builds the timer with PRESCALE=3 and CNT_W=4, so one period is 48 clocks. With a period that short, the bench can sweep every cycle of a period and confirm the flag is low until the exact overflow edge. It can also run several periods back to back to check the wrap, the restart after a partial count, and a clear write placed exactly on an overflow edge. All four enable combinations are checked against both flag states.

// File: rtl/mc_timer_pkg.sv
// Package: shared bit positions for the interval timer register writes.
// Assumes 8-bit write data on both register strobes.
package mc_timer_pkg;
    localparam int unsigned DATA_W      = 8;
    localparam int unsigned CFG_RUN_BIT = 4;   // run / stop-and-zero
    localparam int unsigned CFG_CLR_BIT = 5;   // write 1 clears flag
    localparam int unsigned IEN_SRC_BIT = 4;   // timer source enable
    localparam int unsigned IEN_ALL_BIT = 7;   // global enable
endpackage

// File: rtl/mc_cycle_divider.sv
// Module: machine-cycle divider. Emits a one-clock tick every DIV clocks
// while run is high. Assumes DIV >= 2. Holds zero whenever run is low.
module mc_cycle_divider #(
    parameter int unsigned DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int unsigned PW   = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] phase_q;

    // Tick on the last phase of each machine cycle
    assign tick = run && (phase_q == LAST);

    // Advance phase while running, zero it otherwise
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            phase_q <= '0;
        end else if (phase_q == LAST) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    assert_phase_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q <= LAST);
    assert_phase_zero_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (phase_q == '0));
endmodule

// File: rtl/mc_interval_count.sv
// Module: CNT_W-bit interval counter. Advances on each tick, wraps to
// zero past all-ones and reports a one-clock carry at that edge.
// Assumes tick only arrives while run is high.
module mc_interval_count #(
    parameter int unsigned CNT_W = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic carry
);
    logic [CNT_W-1:0] count_q;

    // Carry when the full count is advanced once more
    assign carry = run && tick && (&count_q);

    // Count ticks; zero while stopped
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            count_q <= '0;
        end else if (tick) begin
            count_q <= count_q + 1'b1;
        end
    end

    assert_count_zero_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (count_q == '0));
    assert_no_carry_stopped_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !carry);
    assert_wrap_to_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (carry && run) |=> (count_q == '0));
endmodule

// File: rtl/mc_ctrl_regs.sv
// Module: control registers. Holds the run bit and the two interrupt
// enables, and decodes the write-1 flag clear pulse. Assumes strobes
// are single-clock qualified writes.
module mc_ctrl_regs
    import mc_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              ien_wr,
    input  logic [DATA_W-1:0] ien_wdata,
    output logic              run,
    output logic              clr_pulse,
    output logic              en_src,
    output logic              en_all
);
    logic unused_cfg_bits;
    assign unused_cfg_bits = ^{cfg_wdata[DATA_W-1:CFG_CLR_BIT+1],
                               cfg_wdata[CFG_RUN_BIT-1:0],
                               ien_wdata[IEN_ALL_BIT-1:IEN_SRC_BIT+1],
                               ien_wdata[IEN_SRC_BIT-1:0]};

    // Clear request exists only in the cycle of the write
    assign clr_pulse = cfg_wr && cfg_wdata[CFG_CLR_BIT];

    // Run bit register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0;
        end else if (cfg_wr) begin
            run <= cfg_wdata[CFG_RUN_BIT];
        end
    end

    // Interrupt enable bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_src <= 1'b0;
            en_all <= 1'b0;
        end else if (ien_wr) begin
            en_src <= ien_wdata[IEN_SRC_BIT];
            en_all <= ien_wdata[IEN_ALL_BIT];
        end
    end

    assert_run_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> $stable(run));
    assert_enables_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ien_wr |=> ($stable(en_src) && $stable(en_all)));
endmodule

// File: rtl/mc_flag_unit.sv
// Module: sticky overflow flag and gated interrupt request. Set wins
// over a simultaneous clear. Assumes carry is a one-clock pulse.
module mc_flag_unit (
    input  logic clk,
    input  logic rst_n,
    input  logic carry,
    input  logic clr_pulse,
    input  logic en_src,
    input  logic en_all,
    output logic flag,
    output logic irq
);
    // Request only when both enables admit the flag
    assign irq = flag && en_src && en_all;

    // Sticky flag: carry sets, clear write resets, carry has priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (carry) begin
            flag <= 1'b1;
        end else if (clr_pulse) begin
            flag <= 1'b0;
        end
    end

    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr_pulse) |=> flag);
    assert_carry_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        carry |=> flag);
    assert_flag_rise_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(carry));
endmodule

// File: rtl/mc_interval_timer.sv
// Module: top of the machine-cycle interval timer. Wires the control
// registers, divider, counter and flag unit. Assumes a single clock domain.
module mc_interval_timer
    import mc_timer_pkg::*;
#(
    parameter int unsigned PRESCALE = 12,
    parameter int unsigned CNT_W    = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              ien_wr,
    input  logic [DATA_W-1:0] ien_wdata,
    output logic              ovf_flag,
    output logic              irq
);
    logic run, clr_pulse, en_src, en_all, tick, carry;

    mc_ctrl_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .ien_wr    (ien_wr),
        .ien_wdata (ien_wdata),
        .run       (run),
        .clr_pulse (clr_pulse),
        .en_src    (en_src),
        .en_all    (en_all)
    );

    mc_cycle_divider #(.DIV(PRESCALE)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    mc_interval_count #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick),
        .carry (carry)
    );

    mc_flag_unit u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .carry     (carry),
        .clr_pulse (clr_pulse),
        .en_src    (en_src),
        .en_all    (en_all),
        .flag      (ovf_flag),
        .irq       (irq)
    );

    assert_irq_needs_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ovf_flag);
    assert_stopped_no_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !ovf_flag) |=> !ovf_flag);
endmodule

// File: tb/tb_mc_interval_timer.sv
module tb_mc_interval_timer;
    localparam int unsigned PRE = 3;
    localparam int unsigned CW  = 4;
    localparam int unsigned N   = PRE * (1 << CW);
    localparam logic [7:0] RUN = 8'h10;
    localparam logic [7:0] CLR = 8'h20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic ien_wr = 1'b0;
    logic [7:0] ien_wdata = 8'h00;
    logic ovf_flag, irq;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    mc_interval_timer #(.PRESCALE(PRE), .CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .ien_wr(ien_wr), .ien_wdata(ien_wdata), .ovf_flag(ovf_flag), .irq(irq)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    // Called at a negedge; the write lands on the next posedge
    task automatic cfg_write(input logic [7:0] v);
        cfg_wr = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_wdata = 8'h00;
    endtask

    task automatic ien_write(input logic [7:0] v);
        ien_wr = 1'b1; ien_wdata = v;
        @(negedge clk);
        ien_wr = 1'b0; ien_wdata = 8'h00;
    endtask

    // Sweep n edges; flag must rise exactly at edge n
    task automatic sweep_to_ovf(input string req, input int n);
        for (int k = 1; k <= n; k++) begin
            @(negedge clk);
            check(req, ovf_flag, (k == n));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", ovf_flag, 1'b0);
        check("R1", irq, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4: stopped timer never sets the flag
        for (int k = 0; k < 2 * N; k++) begin
            @(negedge clk);
            check("R4", ovf_flag, 1'b0);
        end

        // R2: first overflow exactly N edges after start
        cfg_write(RUN);
        sweep_to_ovf("R2", N);

        // R7: clear write on the next overflow edge, carry wins
        repeat (N - 1) @(negedge clk);
        cfg_write(RUN | CLR);
        check("R7", ovf_flag, 1'b1);

        // R6: clear write drops the flag
        cfg_write(RUN | CLR);
        check("R6", ovf_flag, 1'b0);

        // R5: wrap keeps period; next overflow N edges after the last
        sweep_to_ovf("R5", N - 1);

        // R9: data without strobe does nothing
        cfg_wdata = CLR; ien_wdata = 8'h90;
        repeat (4) @(negedge clk);
        check("R9", ovf_flag, 1'b1);
        check("R9", irq, 1'b0);
        cfg_wdata = 8'h00; ien_wdata = 8'h00;

        // R6: flag persists while stopped
        cfg_write(8'h00);
        repeat (10) @(negedge clk);
        check("R6", ovf_flag, 1'b1);

        // R8: all enable combinations with flag set
        for (int e = 0; e < 4; e++) begin
            ien_write({e[1], 2'b00, e[0], 4'h0});
            check("R8", irq, (e == 3));
        end
        cfg_write(CLR);
        check("R8", irq, 1'b0);
        check("R6", ovf_flag, 1'b0);

        // R3: partial run, stop, restart gives a full period
        cfg_write(RUN);
        repeat (20) @(negedge clk);
        cfg_write(8'h00);
        repeat (5) @(negedge clk);
        check("R4", ovf_flag, 1'b0);
        cfg_write(RUN);
        sweep_to_ovf("R3", N);
        check("R8", irq, 1'b1);

        // R8: global enable alone is not enough
        ien_write(8'h80);
        check("R8", irq, 1'b0);
        done = 1'b1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=done");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule